// File: doc/BRIEF.md
# Teller Session Controller

This block is a synchronous controller that takes one customer through a simplified cash-machine session. The session runs in order: a card validity check, PIN entry with one retry, a choice of display language, and then a menu with three choices. Those choices are a savings withdrawal, a balance enquiry and a current-account withdrawal. After each transaction the controller asks whether the customer wants to go on. Either answer returns it to the card stage. A "no" also raises a departure pulse.

Every user action arrives as a one-cycle strobe with a data bus beside it. A stage waits until its own strobe arrives, and strobes meant for other stages are dropped. The block holds two 19-bit balance registers, one per account. These are loaded from parameters at reset and lowered by each granted withdrawal. All outputs are registered and pulse for one cycle after the strobe that caused them. The language index and the two displayed balances are the exception: they hold their value until they are next updated. The block does not read cards, authenticate messages, drive displays or dispense cash.

Top module: `atm_session_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, the controller returns to the card stage and clears every pulse output, `lang_out`, `bal_sav_out` and `bal_cur_out`. It also reloads the savings balance from `SAV_INIT` (default 5000) and the current balance from `CUR_INIT` (default 1200).
- R2: In the card stage, a `card_stb` with `card_ok`=0 raises `invalid` and `buzzer` for exactly one cycle after that edge, and the controller stays in the card stage.
- R3: A `card_stb` with `card_ok`=1 moves the controller to PIN entry. A `pin_stb` whose `pin_code` equals `PIN_VALUE` (default 16'h4321) then leads straight to language selection.
- R4: A wrong first PIN moves the controller to a second-chance stage, where one more correct PIN leads to language selection with no `invalid` pulse.
- R5: A wrong PIN in the second-chance stage raises `invalid` and `buzzer` for one cycle and returns the controller to the card stage.
- R6: In language selection, a `lang_stb` with `lang_sel` below `NUM_LANG` (default 3) stores the index on `lang_out` and opens the menu. An index at or above `NUM_LANG` is ignored.
- R7: Menu codes on `menu_sel` are 2'b00 for savings withdrawal, 2'b01 for balance enquiry and 2'b10 for current withdrawal. Code 2'b11 is ignored and the menu stays open.
- R8: In a withdrawal stage, an `amt_val` no larger than the chosen account's balance pulses `grant_sav` or `grant_cur`. The amount is subtracted from that balance on the same edge. An amount equal to the balance is granted.
- R9: An amount larger than the chosen account's balance pulses `deny` and leaves both balances unchanged.
- R10: A balance enquiry pulses `bal_valid` and loads both balances onto `bal_sav_out` and `bal_cur_out` without changing them.
- R11: After a transaction, a `cont_stb` with `cont_yes`=1 returns to the card stage without `depart`. With `cont_yes`=0 it pulses `depart` for one cycle and returns to the card stage.
- R12: A strobe that does not belong to the current stage has no effect on state, outputs or balances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_stb | input | 1 | Card presented strobe |
| card_ok | input | 1 | Card validity result qualifying `card_stb` |
| pin_stb | input | 1 | PIN entered strobe |
| pin_code | input | PIN_W | Entered PIN value |
| lang_stb | input | 1 | Language chosen strobe |
| lang_sel | input | LANG_W | Chosen language index |
| menu_stb | input | 1 | Menu choice strobe |
| menu_sel | input | 2 | Menu code |
| amt_stb | input | 1 | Withdrawal amount strobe |
| amt_val | input | BAL_W | Requested amount |
| cont_stb | input | 1 | Continue answer strobe |
| cont_yes | input | 1 | 1 = continue, 0 = leave |
| buzzer | output | 1 | Alarm pulse on a rejected card or PIN |
| invalid | output | 1 | Rejection pulse on a rejected card or PIN |
| grant_sav | output | 1 | Savings withdrawal granted pulse |
| grant_cur | output | 1 | Current withdrawal granted pulse |
| deny | output | 1 | Withdrawal refused for insufficient funds |
| bal_valid | output | 1 | Balance display updated pulse |
| bal_sav_out | output | BAL_W | Savings balance shown by the last enquiry |
| bal_cur_out | output | BAL_W | Current balance shown by the last enquiry |
| lang_out | output | LANG_W | Accepted language index |
| depart | output | 1 | Session ended by the customer |

## Verification
A controller stuck in the wrong stage shows no pulse at the time the next strobe would produce one. The expected `grant_*`, `deny`, `bal_valid`, `depart` or `lang_out` change is missing one cycle after that strobe. Wrong balance arithmetic stays hidden until the next enquiry or withdrawal near the limit. For that reason each session ends in a balance enquiry, and the withdrawal amounts sit exactly at and just past each balance. A lost PIN attempt count shows on the second wrong PIN: the `invalid` pulse either goes missing or comes one attempt too early.

// File: rtl/atm_pkg.sv
package atm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PIN1,
    ST_PIN2,
    ST_LANG,
    ST_MENU,
    ST_AMT_SAV,
    ST_AMT_CUR,
    ST_ASK
  } sess_state_t;

  localparam logic [1:0] MENU_SAV = 2'b00;
  localparam logic [1:0] MENU_BAL = 2'b01;
  localparam logic [1:0] MENU_CUR = 2'b10;

  localparam int ACCT_SAV = 0;
  localparam int ACCT_CUR = 1;
  localparam int NUM_ACCT = 2;
endpackage

// File: rtl/atm_pin_gate.sv
module atm_pin_gate #(
  parameter int              PIN_W     = 16,
  parameter logic [PIN_W-1:0] PIN_VALUE = 16'h4321
) (
  input  logic [PIN_W-1:0] pin_code,
  output logic             match
);
  assign match = (pin_code == PIN_VALUE);
endmodule

// File: rtl/atm_ledger.sv
module atm_ledger #(
  parameter int                       NUM_ACCT  = 2,
  parameter int                       BAL_W     = 19,
  parameter logic [NUM_ACCT*BAL_W-1:0] INIT_FLAT = '0,
  localparam int                      IDX_W     = (NUM_ACCT > 1) ? $clog2(NUM_ACCT) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          debit_en,
  input  logic [IDX_W-1:0]              debit_idx,
  input  logic [BAL_W-1:0]              debit_amt,
  output logic [NUM_ACCT-1:0][BAL_W-1:0] bal_q,
  output logic [NUM_ACCT-1:0]           covers
);
  for (genvar a = 0; a < NUM_ACCT; a++) begin : g_acct
    logic [BAL_W-1:0] acc_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q <= INIT_FLAT[a*BAL_W +: BAL_W];
      end else if (debit_en && (debit_idx == IDX_W'(a))) begin
        acc_q <= acc_q - debit_amt;
      end
    end

    assign bal_q[a]  = acc_q;
    assign covers[a] = (acc_q >= debit_amt);
  end
endmodule

// File: rtl/atm_session_ctrl.sv
module atm_session_ctrl
  import atm_pkg::*;
#(
  parameter int               PIN_W     = 16,
  parameter logic [PIN_W-1:0] PIN_VALUE = 16'h4321,
  parameter int               LANG_W    = 2,
  parameter int               NUM_LANG  = 3,
  parameter int               BAL_W     = 19,
  parameter logic [BAL_W-1:0] SAV_INIT  = 19'd5000,
  parameter logic [BAL_W-1:0] CUR_INIT  = 19'd1200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              card_stb,
  input  logic              card_ok,
  input  logic              pin_stb,
  input  logic [PIN_W-1:0]  pin_code,
  input  logic              lang_stb,
  input  logic [LANG_W-1:0] lang_sel,
  input  logic              menu_stb,
  input  logic [1:0]        menu_sel,
  input  logic              amt_stb,
  input  logic [BAL_W-1:0]  amt_val,
  input  logic              cont_stb,
  input  logic              cont_yes,
  output logic              buzzer,
  output logic              invalid,
  output logic              grant_sav,
  output logic              grant_cur,
  output logic              deny,
  output logic              bal_valid,
  output logic [BAL_W-1:0]  bal_sav_out,
  output logic [BAL_W-1:0]  bal_cur_out,
  output logic [LANG_W-1:0] lang_out,
  output logic              depart
);
  localparam logic [NUM_ACCT*BAL_W-1:0] INIT_FLAT = {CUR_INIT, SAV_INIT};

  sess_state_t                   state;
  logic                          pin_match;
  logic                          lang_ok;
  logic                          in_amt;
  logic                          acct_cur;
  logic                          debit_en;
  logic [NUM_ACCT-1:0][BAL_W-1:0] bal_q;
  logic [NUM_ACCT-1:0]           covers;
  logic [BAL_W-1:0]              sav_bal;
  logic [BAL_W-1:0]              cur_bal;

  atm_pin_gate #(
    .PIN_W    (PIN_W),
    .PIN_VALUE(PIN_VALUE)
  ) u_pin_gate (
    .pin_code(pin_code),
    .match   (pin_match)
  );

  assign in_amt   = (state == ST_AMT_SAV) || (state == ST_AMT_CUR);
  assign acct_cur = (state == ST_AMT_CUR);
  assign debit_en = in_amt && amt_stb && covers[acct_cur];
  assign lang_ok  = ({1'b0, lang_sel} < (LANG_W+1)'(NUM_LANG));

  atm_ledger #(
    .NUM_ACCT (NUM_ACCT),
    .BAL_W    (BAL_W),
    .INIT_FLAT(INIT_FLAT)
  ) u_ledger (
    .clk      (clk),
    .rst      (rst),
    .debit_en (debit_en),
    .debit_idx(acct_cur),
    .debit_amt(amt_val),
    .bal_q    (bal_q),
    .covers   (covers)
  );

  assign sav_bal = bal_q[ACCT_SAV];
  assign cur_bal = bal_q[ACCT_CUR];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      buzzer      <= 1'b0;
      invalid     <= 1'b0;
      grant_sav   <= 1'b0;
      grant_cur   <= 1'b0;
      deny        <= 1'b0;
      bal_valid   <= 1'b0;
      depart      <= 1'b0;
      bal_sav_out <= '0;
      bal_cur_out <= '0;
      lang_out    <= '0;
    end else begin
      buzzer    <= 1'b0;
      invalid   <= 1'b0;
      grant_sav <= 1'b0;
      grant_cur <= 1'b0;
      deny      <= 1'b0;
      bal_valid <= 1'b0;
      depart    <= 1'b0;
      case (state)
        ST_IDLE: if (card_stb) begin
          if (card_ok) begin
            state <= ST_PIN1;
          end else begin
            invalid <= 1'b1;
            buzzer  <= 1'b1;
          end
        end
        ST_PIN1: if (pin_stb) begin
          state <= pin_match ? ST_LANG : ST_PIN2;
        end
        ST_PIN2: if (pin_stb) begin
          if (pin_match) begin
            state <= ST_LANG;
          end else begin
            invalid <= 1'b1;
            buzzer  <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_LANG: if (lang_stb && lang_ok) begin
          lang_out <= lang_sel;
          state    <= ST_MENU;
        end
        ST_MENU: if (menu_stb) begin
          case (menu_sel)
            MENU_SAV: state <= ST_AMT_SAV;
            MENU_CUR: state <= ST_AMT_CUR;
            MENU_BAL: begin
              bal_valid   <= 1'b1;
              bal_sav_out <= sav_bal;
              bal_cur_out <= cur_bal;
              state       <= ST_ASK;
            end
            default: state <= ST_MENU;
          endcase
        end
        ST_AMT_SAV, ST_AMT_CUR: if (amt_stb) begin
          if (covers[acct_cur]) begin
            grant_sav <= !acct_cur;
            grant_cur <= acct_cur;
          end else begin
            deny <= 1'b1;
          end
          state <= ST_ASK;
        end
        ST_ASK: if (cont_stb) begin
          depart <= !cont_yes;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/atm_session_chk.sv
module atm_session_chk #(
  parameter int               BAL_W    = 19,
  parameter logic [BAL_W-1:0] SAV_INIT = 19'd5000,
  parameter logic [BAL_W-1:0] CUR_INIT = 19'd1200
) (
  input logic             clk,
  input logic             rst,
  input logic             card_stb,
  input logic             pin_stb,
  input logic             cont_stb,
  input logic             cont_yes,
  input logic [BAL_W-1:0] amt_val,
  input logic             buzzer,
  input logic             invalid,
  input logic             grant_sav,
  input logic             grant_cur,
  input logic             deny,
  input logic             bal_valid,
  input logic [BAL_W-1:0] bal_sav_out,
  input logic [BAL_W-1:0] bal_cur_out,
  input logic             depart,
  input logic [BAL_W-1:0] sav_bal,
  input logic [BAL_W-1:0] cur_bal
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      assert_reset_state_R1: assert (sav_bal == SAV_INIT && cur_bal == CUR_INIT &&
                                     !grant_sav && !grant_cur && !deny && !invalid &&
                                     !buzzer && !depart && !bal_valid)
        else $error("reset state wrong");
    end
  end

  // R2 and R5: a rejection only follows a card or PIN strobe.
  assert_reject_cause_R5: assert property (@(posedge clk) disable iff (rst)
    invalid |-> buzzer && ($past(card_stb) || $past(pin_stb)));

  assert_grant_sav_debit_R8: assert property (@(posedge clk) disable iff (rst)
    grant_sav |-> (sav_bal == $past(sav_bal) - $past(amt_val)) && $stable(cur_bal));

  assert_grant_cur_debit_R8: assert property (@(posedge clk) disable iff (rst)
    grant_cur |-> (cur_bal == $past(cur_bal) - $past(amt_val)) && $stable(sav_bal));

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant_sav, grant_cur, deny}));

  assert_deny_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    deny |-> $stable(sav_bal) && $stable(cur_bal) && ($past(amt_val) > 0));

  assert_enquiry_view_R10: assert property (@(posedge clk) disable iff (rst)
    bal_valid |-> bal_sav_out == sav_bal && bal_cur_out == cur_bal &&
                  $stable(sav_bal) && $stable(cur_bal));

  assert_depart_cause_R11: assert property (@(posedge clk) disable iff (rst)
    depart |-> $past(cont_stb) && !$past(cont_yes));
endmodule

bind atm_session_ctrl atm_session_chk #(
  .BAL_W   (BAL_W),
  .SAV_INIT(SAV_INIT),
  .CUR_INIT(CUR_INIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .card_stb   (card_stb),
  .pin_stb    (pin_stb),
  .cont_stb   (cont_stb),
  .cont_yes   (cont_yes),
  .amt_val    (amt_val),
  .buzzer     (buzzer),
  .invalid    (invalid),
  .grant_sav  (grant_sav),
  .grant_cur  (grant_cur),
  .deny       (deny),
  .bal_valid  (bal_valid),
  .bal_sav_out(bal_sav_out),
  .bal_cur_out(bal_cur_out),
  .depart     (depart),
  .sav_bal    (sav_bal),
  .cur_bal    (cur_bal)
);

// File: tb/atm_session_ctrl_bench.sv
module atm_session_ctrl_bench;
  localparam int          PIN_W  = 16;
  localparam int          LANG_W = 2;
  localparam int          BAL_W  = 19;
  localparam logic [15:0] GOOD   = 16'h4321;
  localparam logic [15:0] BAD    = 16'h1111;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              card_stb = 0, card_ok = 0, pin_stb = 0, lang_stb = 0;
  logic              menu_stb = 0, amt_stb = 0, cont_stb = 0, cont_yes = 0;
  logic [PIN_W-1:0]  pin_code = '0;
  logic [LANG_W-1:0] lang_sel = '0;
  logic [1:0]        menu_sel = '0;
  logic [BAL_W-1:0]  amt_val = '0;
  logic              buzzer, invalid, grant_sav, grant_cur, deny, bal_valid, depart;
  logic [BAL_W-1:0]  bal_sav_out, bal_cur_out;
  logic [LANG_W-1:0] lang_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int exp_sav = 5000;
  int exp_cur = 1200;

  always #4 clk = ~clk;

  atm_session_ctrl u_atm_session_ctrl (
    .clk(clk), .rst(rst),
    .card_stb(card_stb), .card_ok(card_ok),
    .pin_stb(pin_stb), .pin_code(pin_code),
    .lang_stb(lang_stb), .lang_sel(lang_sel),
    .menu_stb(menu_stb), .menu_sel(menu_sel),
    .amt_stb(amt_stb), .amt_val(amt_val),
    .cont_stb(cont_stb), .cont_yes(cont_yes),
    .buzzer(buzzer), .invalid(invalid),
    .grant_sav(grant_sav), .grant_cur(grant_cur), .deny(deny),
    .bal_valid(bal_valid), .bal_sav_out(bal_sav_out), .bal_cur_out(bal_cur_out),
    .lang_out(lang_out), .depart(depart)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Each strobe is raised at a falling edge and dropped at the next one,
  // where the registered response is already visible.
  task automatic do_card(input logic ok);
    @(negedge clk); card_stb = 1; card_ok = ok;
    @(negedge clk); card_stb = 0;
  endtask
  task automatic do_pin(input logic [PIN_W-1:0] c);
    @(negedge clk); pin_stb = 1; pin_code = c;
    @(negedge clk); pin_stb = 0;
  endtask
  task automatic do_lang(input logic [LANG_W-1:0] l);
    @(negedge clk); lang_stb = 1; lang_sel = l;
    @(negedge clk); lang_stb = 0;
  endtask
  task automatic do_menu(input logic [1:0] m);
    @(negedge clk); menu_stb = 1; menu_sel = m;
    @(negedge clk); menu_stb = 0;
  endtask
  task automatic do_amt(input int a);
    @(negedge clk); amt_stb = 1; amt_val = BAL_W'(a);
    @(negedge clk); amt_stb = 0;
  endtask
  task automatic do_cont(input logic y);
    @(negedge clk); cont_stb = 1; cont_yes = y;
    @(negedge clk); cont_stb = 0;
  endtask

  task automatic enquiry(string req);
    do_menu(2'b01);
    chk(req, "bal_valid", bal_valid, 1);
    chk(req, "savings shown", bal_sav_out, exp_sav);
    chk(req, "current shown", bal_cur_out, exp_cur);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", "invalid", invalid, 0);
    chk("R1", "buzzer", buzzer, 0);
    chk("R1", "grants", grant_sav | grant_cur, 0);
    chk("R1", "depart", depart, 0);
    chk("R1", "lang_out", lang_out, 0);
  endtask

  task automatic t_bad_card_then_enquiry;
    do_card(0);
    chk("R2", "invalid on bad card", invalid, 1);
    chk("R2", "buzzer on bad card", buzzer, 1);
    @(negedge clk);
    chk("R2", "invalid one cycle", invalid, 0);
    do_pin(GOOD);
    do_lang(2'd1);
    chk("R12", "lang ignored in card stage", lang_out, 0);
    do_menu(2'b01);
    chk("R12", "enquiry ignored in card stage", bal_valid, 0);
    do_card(1);
    chk("R3", "no reject on good card", invalid, 0);
    do_pin(GOOD);
    chk("R3", "no reject on good pin", invalid, 0);
    do_lang(2'd1);
    chk("R6", "lang stored", lang_out, 1);
    enquiry("R10");
    chk("R1", "initial savings", bal_sav_out, 5000);
    chk("R1", "initial current", bal_cur_out, 1200);
    do_cont(1);
    chk("R11", "no depart on yes", depart, 0);
  endtask

  task automatic t_retry_savings;
    do_card(1);
    do_pin(BAD);
    chk("R4", "no reject on first wrong pin", invalid, 0);
    do_pin(GOOD);
    chk("R4", "second pin accepted", invalid, 0);
    do_lang(2'd3);
    chk("R6", "out-of-range lang ignored", lang_out, 1);
    do_lang(2'd2);
    chk("R6", "lang 2 stored", lang_out, 2);
    do_menu(2'b11);
    chk("R7", "code 3 ignored", bal_valid, 0);
    do_amt(10);
    chk("R12", "amount ignored in menu", grant_sav | grant_cur | deny, 0);
    do_menu(2'b00);
    do_amt(800);
    exp_sav -= 800;
    chk("R8", "savings grant", grant_sav, 1);
    chk("R8", "no current grant", grant_cur, 0);
    do_cont(0);
    chk("R11", "depart on no", depart, 1);
    @(negedge clk);
    chk("R11", "depart one cycle", depart, 0);
  endtask

  task automatic t_lockout;
    do_card(1);
    do_pin(BAD);
    do_pin(BAD);
    chk("R5", "invalid on second wrong pin", invalid, 1);
    chk("R5", "buzzer on second wrong pin", buzzer, 1);
    do_lang(2'd0);
    chk("R5", "back in card stage", lang_out, 2);
  endtask

  task automatic t_limits;
    do_card(1); do_pin(GOOD); do_lang(2'd0);
    chk("R6", "lang 0 stored", lang_out, 0);
    do_menu(2'b10);
    do_amt(1201);
    chk("R9", "current overdraw denied", deny, 1);
    chk("R9", "no current grant", grant_cur, 0);
    do_cont(1);
    do_card(1); do_pin(GOOD); do_lang(2'd0);
    do_menu(2'b10);
    do_amt(1200);
    exp_cur -= 1200;
    chk("R8", "exact balance granted", grant_cur, 1);
    chk("R8", "no deny on exact", deny, 0);
    do_cont(1);
    do_card(1); do_pin(GOOD); do_lang(2'd0);
    do_menu(2'b00);
    do_amt(exp_sav + 1);
    chk("R9", "savings overdraw denied", deny, 1);
    do_cont(1);
    do_card(1); do_pin(GOOD); do_lang(2'd0);
    enquiry("R9");
    do_cont(0);
  endtask

  initial begin
    t_reset();
    t_bad_card_then_enquiry();
    t_retry_savings();
    t_lockout();
    t_limits();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule